// File: doc/BRIEF.md
# Pin-Event Interrupt Controller for General-Purpose I/O

This block runs 32 general-purpose pins behind a word-wide register bus that has an address, a write strobe, write data and combinational read data. For each pin, software sets whether it drives or listens, whether its driver is open-drain, and the level it drives. The controller synchronizes every pad input. It then watches each pin for level changes and records each qualifying change in a sticky event register. An enable register selects which recorded events raise the single interrupt line. A handler reads the event register, services the pins it finds there, and clears their bits by writing ones.

A build-time parameter picks the sense format. In the narrow format, one control bit per pin selects falling-only or any-edge detection. In the wide format, two control bits per pin, held in two registers, also allow rising-only detection or no detection. A second build option makes the last few pins input-only.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction, open-drain, output, event, enable and sense registers are all zero, `irq` is low and `pad_oe` is zero.
- R2: Pin p is held in bit 31-p of every per-pin register, so pin 0 is the MSB. `bus_addr` carries the word index: 0 direction, 1 open-drain, 2 data, 3 event, 4 enable, 5 sense A, 6 sense B. Index 7 reads as zero and ignores writes.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. A read of the data word returns the output latch on output pins and the synchronized pad level on input pins.
- R4: A pad level reaches the data read path two clock edges after it is applied.
- R5: In the narrow format (`TWO_BIT_SENSE`=0), a sense A bit of 0 records both rising and falling edges and a bit of 1 records falling edges only.
- R6: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R7: `irq` is high exactly when some pin has both its event bit and its enable bit set.
- R8: In the wide format, pins 0-15 take their codes from sense A and pins 16-31 from sense B, with pin p at bits [2*(15 - p mod 16) +: 2]. Code 00 records any edge, 01 rising, 10 falling and 11 none.
- R9: In the narrow format, sense B reads as zero and ignores writes.
- R10: An output pin with its open-drain bit at 0 drives both levels. With the open-drain bit at 1, data 0 drives low and data 1 releases the pin (`pad_oe` low). `pad_out` is low for open-drain pins.
- R11: With `IN_ONLY_CNT`=N, the direction bits of the last N pins (bits N-1..0) ignore writes, read as 0, and never drive.
- R12: If a pin edge and a write-one-to-clear of that pin's event bit hit the same clock edge, the event bit ends up set.
- R13: An edge applied to the pad appears in the event register, and on `irq` if enabled, after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Level to drive per pin |
| pad_oe | output | 32 | Driver enable per pin |
| irq | output | 1 | Interrupt request |

## Verification
The software clear of the event register and the latching of a new pin edge can fall on the same clock edge. The bench provokes this by applying a pad change and then issuing the clearing write exactly two cycles later, so that the write lands on the edge that records the event. It judges the outcome by reading the event word back and expecting the bit still set. The same collision is also compared cycle by cycle against a behavioural model, in both sense formats.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int GPIO_W = 32;
    localparam int SLOT_W = 3;

    typedef enum logic [SLOT_W-1:0] {
        REG_DIR     = 3'd0,
        REG_ODRAIN  = 3'd1,
        REG_DATA    = 3'd2,
        REG_EVENT   = 3'd3,
        REG_ENABLE  = 3'd4,
        REG_SENSE_A = 3'd5,
        REG_SENSE_B = 3'd6,
        REG_NONE    = 3'd7
    } reg_slot_e;

    typedef struct packed {
        logic [GPIO_W-1:0] dir;
        logic [GPIO_W-1:0] odrain;
        logic [GPIO_W-1:0] dout;
        logic [GPIO_W-1:0] evt;
        logic [GPIO_W-1:0] enable;
        logic [GPIO_W-1:0] sense_a;
        logic [GPIO_W-1:0] sense_b;
    } gpio_state_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] lvl_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end
endmodule

// File: rtl/gpio_sense_map.sv
// Turns the sense registers into one 2-bit code per bit position:
// 00 any edge, 01 rising, 10 falling, 11 none.
module gpio_sense_map #(
    parameter int W       = 32,
    parameter bit TWO_BIT = 1'b0
) (
    input  logic [W-1:0]   sense_a,
    input  logic [W-1:0]   sense_b,
    output logic [2*W-1:0] code
);
    localparam int HALF = W / 2;

    if (!TWO_BIT) begin : g_narrow
        // sense_b is held at zero in this format, so codes are 10 or 00
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign code[2*i +: 2] = {sense_a[i], sense_b[i]};
        end
    end else begin : g_wide
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= HALF) begin : g_hi
                assign code[2*i +: 2] = sense_a[2*(i-HALF) +: 2];
            end else begin : g_lo
                assign code[2*i +: 2] = sense_b[2*i +: 2];
            end
        end
    end
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0]   lvl,
    input  logic [W-1:0]   prev,
    input  logic [2*W-1:0] code,
    output logic [W-1:0]   hit
);
    logic [W-1:0] rise;
    logic [W-1:0] fall;

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic h;
        always_comb begin
            unique case (code[2*i +: 2])
                2'b00:   h = rise[i] | fall[i];
                2'b01:   h = rise[i];
                2'b10:   h = fall[i];
                default: h = 1'b0;
            endcase
        end
        assign hit[i] = h;
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_irq_pkg::*;
(
    input  reg_slot_e         slot,
    input  gpio_state_t       st,
    input  logic [GPIO_W-1:0] lvl,
    output logic [GPIO_W-1:0] rdata
);
    always_comb begin
        unique case (slot)
            REG_DIR:     rdata = st.dir;
            REG_ODRAIN:  rdata = st.odrain;
            REG_DATA:    rdata = (st.dout & st.dir) | (lvl & ~st.dir);
            REG_EVENT:   rdata = st.evt;
            REG_ENABLE:  rdata = st.enable;
            REG_SENSE_A: rdata = st.sense_a;
            REG_SENSE_B: rdata = st.sense_b;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter bit TWO_BIT_SENSE = 1'b0,
    parameter int IN_ONLY_CNT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pad_in,
    output logic [GPIO_W-1:0] pad_out,
    output logic [GPIO_W-1:0] pad_oe,
    output logic              irq
);
    function automatic logic [GPIO_W-1:0] dir_wmask_f(input int n);
        logic [GPIO_W-1:0] m;
        for (int i = 0; i < GPIO_W; i++) m[i] = (i >= n);
        return m;
    endfunction

    localparam logic [GPIO_W-1:0] DIR_WMASK = dir_wmask_f(IN_ONLY_CNT);

    gpio_state_t         state_d, state_q;
    reg_slot_e           slot;
    logic [GPIO_W-1:0]   lvl_q, prev_q, hit, clr;
    logic [2*GPIO_W-1:0] code;

    assign slot = reg_slot_e'(bus_addr);

    gpio_sync #(.W(GPIO_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .lvl_q  (lvl_q),
        .prev_q (prev_q)
    );

    gpio_sense_map #(.W(GPIO_W), .TWO_BIT(TWO_BIT_SENSE)) u_sense (
        .sense_a (state_q.sense_a),
        .sense_b (state_q.sense_b),
        .code    (code)
    );

    gpio_edge_detect #(.W(GPIO_W)) u_edge (
        .lvl  (lvl_q),
        .prev (prev_q),
        .code (code),
        .hit  (hit)
    );

    gpio_read_mux u_rmux (
        .slot  (slot),
        .st    (state_q),
        .lvl   (lvl_q),
        .rdata (bus_rdata)
    );

    always_comb begin
        state_d = state_q;
        clr     = '0;
        if (bus_we) begin
            unique case (slot)
                REG_DIR:     state_d.dir     = bus_wdata & DIR_WMASK;
                REG_ODRAIN:  state_d.odrain  = bus_wdata;
                REG_DATA:    state_d.dout    = bus_wdata;
                REG_EVENT:   clr             = bus_wdata;
                REG_ENABLE:  state_d.enable  = bus_wdata;
                REG_SENSE_A: state_d.sense_a = bus_wdata;
                REG_SENSE_B: if (TWO_BIT_SENSE) state_d.sense_b = bus_wdata;
                default:     ;
            endcase
        end
        // a fresh edge overrides a clear of the same bit
        state_d.evt = (state_q.evt & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pad_oe  = state_q.dir & ~(state_q.odrain & state_q.dout);
    assign pad_out = state_q.dout & ~state_q.odrain;
    assign irq     = |(state_q.evt & state_q.enable);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int IN_ONLY_CNT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SLOT_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              irq,
    input logic [GPIO_W-1:0] pad_oe,
    input logic [GPIO_W-1:0] dir,
    input logic [GPIO_W-1:0] evt,
    input logic [GPIO_W-1:0] enable,
    input logic [GPIO_W-1:0] lvl,
    input logic [GPIO_W-1:0] prev
);
    localparam logic [GPIO_W-1:0] ONE = 1;
    localparam logic [GPIO_W-1:0] LOW_PINS = (ONE << IN_ONLY_CNT) - ONE;

    a_r1_irq_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && pad_oe == '0));

    a_r6_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        |($past(evt) & ~evt) |-> ($past(bus_we) && $past(bus_addr) == REG_EVENT));

    a_r5_event_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt & ~$past(evt)) |-> ($past(lvl) != $past(prev)));

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (enable != '0 && evt != '0));

    a_r10_oe_only_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir) == '0);

    if (IN_ONLY_CNT > 0) begin : g_inonly
        a_r11_inputs_never_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_oe & LOW_PINS) == '0);
    end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.IN_ONLY_CNT(IN_ONLY_CNT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .irq      (irq),
    .pad_oe   (pad_oe),
    .dir      (state_q.dir),
    .evt      (state_q.evt),
    .enable   (state_q.enable),
    .lvl      (lvl_q),
    .prev     (prev_q)
);

// File: tb/tb_gpio_irq_ctrl.sv
// Behavioural reference: pin-indexed loops over a queue of pad samples.
module gpio_ref_model #(
    parameter bit TWO = 1'b0,
    parameter int INONLY = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  addr,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic [31:0] pad,
    output logic [31:0] exp_rdata,
    output logic [31:0] exp_out,
    output logic [31:0] exp_oe,
    output logic        exp_irq
);
    logic [31:0] r_dir, r_od, r_dat, r_evt, r_en, r_sa, r_sb, seen;
    logic [31:0] hist [$];

    initial begin
        hist = '{32'h0, 32'h0, 32'h0};
        {r_dir, r_od, r_dat, r_evt, r_en, r_sa, r_sb, seen} = '0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            {r_dir, r_od, r_dat, r_evt, r_en, r_sa, r_sb, seen} = '0;
            hist = '{32'h0, 32'h0, 32'h0};
        end else begin
            logic [31:0] hits;
            hits = '0;
            for (int p = 0; p < 32; p++) begin
                int b, idx;
                logic r, f, h;
                logic [1:0] cd;
                b = 31 - p;
                r = hist[1][b] & ~hist[2][b];
                f = ~hist[1][b] & hist[2][b];
                if (TWO) begin
                    idx = 2 * (15 - (p % 16));
                    cd = (p < 16) ? r_sa[idx +: 2] : r_sb[idx +: 2];
                    case (cd)
                        2'b00:   h = r | f;
                        2'b01:   h = r;
                        2'b10:   h = f;
                        default: h = 1'b0;
                    endcase
                end else begin
                    h = r_sa[b] ? f : (r | f);
                end
                hits[b] = h;
            end
            if (we) begin
                case (addr)
                    3'd0: for (int p = 0; p < 32; p++) r_dir[31-p] = (p >= 32 - INONLY) ? 1'b0 : wdata[31-p];
                    3'd1: r_od = wdata;
                    3'd2: r_dat = wdata;
                    3'd3: r_evt = r_evt & ~wdata;
                    3'd4: r_en = wdata;
                    3'd5: r_sa = wdata;
                    3'd6: if (TWO) r_sb = wdata;
                    default: ;
                endcase
            end
            r_evt = r_evt | hits;
            hist.push_front(pad);
            void'(hist.pop_back());
            seen = hist[1];
        end
    end

    always_comb begin
        for (int p = 0; p < 32; p++) begin
            exp_oe[31-p]  = r_dir[31-p] && !(r_od[31-p] && r_dat[31-p]);
            exp_out[31-p] = r_dat[31-p] && !r_od[31-p];
        end
        case (addr)
            3'd0: exp_rdata = r_dir;
            3'd1: exp_rdata = r_od;
            3'd2: for (int p = 0; p < 32; p++) exp_rdata[31-p] = r_dir[31-p] ? r_dat[31-p] : seen[31-p];
            3'd3: exp_rdata = r_evt;
            3'd4: exp_rdata = r_en;
            3'd5: exp_rdata = r_sa;
            3'd6: exp_rdata = r_sb;
            default: exp_rdata = '0;
        endcase
        exp_irq = (r_evt & r_en) != 0;
    end
endmodule

module tb_gpio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_DIR = 3'd0, A_OD = 3'd1, A_DAT = 3'd2, A_EVT = 3'd3,
                           A_EN = 3'd4, A_SA = 3'd5, A_SB = 3'd6, A_NONE = 3'd7;

    logic        clk, rst_n, we, done;
    logic [2:0]  addr;
    logic [31:0] wdata, pad;
    logic [31:0] a_rdata, a_out, a_oe, w_rdata, w_out, w_oe;
    logic        a_irq, w_irq;
    logic [31:0] ma_rdata, ma_out, ma_oe, mw_rdata, mw_out, mw_oe;
    logic        ma_irq, mw_irq;
    int n_chk = 0;
    int n_fail = 0;

    gpio_irq_ctrl #(.TWO_BIT_SENSE(1'b0), .IN_ONLY_CNT(0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(a_rdata), .pad_in(pad), .pad_out(a_out), .pad_oe(a_oe), .irq(a_irq));

    gpio_irq_ctrl #(.TWO_BIT_SENSE(1'b1), .IN_ONLY_CNT(4)) dut_w (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(w_rdata), .pad_in(pad), .pad_out(w_out), .pad_oe(w_oe), .irq(w_irq));

    gpio_ref_model #(.TWO(1'b0), .INONLY(0)) ref_a (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .pad(pad),
        .exp_rdata(ma_rdata), .exp_out(ma_out), .exp_oe(ma_oe), .exp_irq(ma_irq));

    gpio_ref_model #(.TWO(1'b1), .INONLY(4)) ref_w (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .pad(pad),
        .exp_rdata(mw_rdata), .exp_out(mw_out), .exp_oe(mw_oe), .exp_irq(mw_irq));

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // every-cycle comparison against the behavioural model
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R3 narrow read port vs model", a_rdata, ma_rdata);
            chk("R7 narrow irq vs model", {31'b0, a_irq}, {31'b0, ma_irq});
            chk("R10 narrow pad_oe vs model", a_oe, ma_oe);
            chk("R10 narrow pad_out vs model", a_out, ma_out);
            chk("R8 wide read port vs model", w_rdata, mw_rdata);
            chk("R7 wide irq vs model", {31'b0, w_irq}, {31'b0, mw_irq});
            chk("R11 wide pad_oe vs model", w_oe, mw_oe);
            chk("R10 wide pad_out vs model", w_out, mw_out);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [2:0] a,
                        input logic [31:0] ea, input logic [31:0] ew);
        @(negedge clk);
        addr = a;
        #1;
        chk({tag, " (narrow)"}, a_rdata, ea);
        chk({tag, " (wide)"}, w_rdata, ew);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        done = 1'b0;
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; we = 1'b0; addr = A_DIR; wdata = '0; pad = '0;
        settle(3);
        chk("R1 irq in reset", {31'b0, a_irq | w_irq}, 32'h0);
        chk("R1 pad_oe in reset narrow", a_oe, 32'h0);
        chk("R1 pad_oe in reset wide", w_oe, 32'h0);
        rst_n = 1'b1;
        peek("R1 event after reset", A_EVT, 32'h0, 32'h0);
        peek("R1 enable after reset", A_EN, 32'h0, 32'h0);
        peek("R1 direction after reset", A_DIR, 32'h0, 32'h0);

        // R11 input-only tail pins, R3 direction drive
        wr(A_DIR, 32'hFFFF_FFFF);
        peek("R11 direction readback", A_DIR, 32'hFFFF_FFFF, 32'hFFFF_FFF0);
        chk("R11 wide never drives tail pins", w_oe, 32'hFFFF_FFF0);
        chk("R3 all outputs drive", a_oe, 32'hFFFF_FFFF);

        // R2/R3 pin 0 is the MSB, outputs read their latch
        wr(A_DIR, 32'hF000_0000);
        wr(A_DAT, 32'hA000_0000);
        peek("R3 data read mixes latch and pads", A_DAT, 32'hA000_0000, 32'hA000_0000);
        chk("R2 pins 0 and 2 drive high", a_out, 32'hA000_0000);
        chk("R3 only pins 0-3 enabled", a_oe, 32'hF000_0000);

        // R10 open drain
        wr(A_OD, 32'h8000_0000);
        #1;
        chk("R10 open-drain high releases", a_oe, 32'h7000_0000);
        chk("R10 open-drain never drives high", a_out, 32'h2000_0000);
        wr(A_DAT, 32'h0000_0000);
        #1;
        chk("R10 open-drain low drives", a_oe, 32'hF000_0000);
        wr(A_OD, 32'h0);

        // R4 two-edge synchronizer latency
        @(negedge clk);
        pad = 32'h0000_00FF; addr = A_DAT;
        @(negedge clk); #1;
        chk("R4 pad not yet visible", a_rdata, 32'h0);
        @(negedge clk); #1;
        chk("R4 pad visible after two edges", a_rdata, 32'h0000_00FF);
        settle(2);
        peek("R5 rising edges latched in any-edge mode", A_EVT, 32'h0000_00FF, 32'h0000_00FF);

        // R6 write-one-to-clear
        wr(A_EVT, 32'h0000_000F);
        peek("R6 ones clear", A_EVT, 32'h0000_00F0, 32'h0000_00F0);
        wr(A_EVT, 32'h0);
        peek("R6 zeros leave bits", A_EVT, 32'h0000_00F0, 32'h0000_00F0);
        wr(A_EVT, 32'hFFFF_FFFF);
        peek("R6 clear all", A_EVT, 32'h0, 32'h0);

        // R7 enable gating
        @(negedge clk); pad = 32'h0;
        settle(4);
        chk("R7 no irq while enables are zero", {31'b0, a_irq | w_irq}, 32'h0);
        wr(A_EN, 32'h0000_0001);
        #1;
        chk("R7 irq with enabled event narrow", {31'b0, a_irq}, 32'h1);
        chk("R7 irq with enabled event wide", {31'b0, w_irq}, 32'h1);
        wr(A_EVT, 32'h0000_0001);
        #1;
        chk("R7 irq drops after clear", {31'b0, a_irq | w_irq}, 32'h0);

        // R13 edge-to-irq latency
        @(negedge clk); pad = 32'h0000_0001;
        @(negedge clk); #1;
        chk("R13 irq low after one edge", {31'b0, a_irq}, 32'h0);
        @(negedge clk); #1;
        chk("R13 irq low after two edges", {31'b0, a_irq}, 32'h0);
        @(negedge clk); #1;
        chk("R13 irq high after three edges", {31'b0, a_irq}, 32'h1);
        wr(A_EN, 32'h0);

        // R5 falling-only, R8 code 11 on pins 0-15 in wide format
        wr(A_SA, 32'hFFFF_FFFF);
        wr(A_EVT, 32'hFFFF_FFFF);
        @(negedge clk); pad = 32'h0000_00FF;
        settle(4);
        peek("R5 falling-only ignores rises", A_EVT, 32'h0, 32'h0000_00FE);
        @(negedge clk); pad = 32'h0;
        settle(4);
        peek("R5 falling-only records falls", A_EVT, 32'h0000_00FF, 32'h0000_00FF);

        // R8 wide codes on pins 31 (01), 30 (10), 29 (11); R9 narrow sense B
        wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_SB, 32'h0000_0039);
        peek("R9 narrow sense B reads zero", A_SB, 32'h0, 32'h0000_0039);
        @(negedge clk); pad = 32'h0000_0007;
        settle(4);
        peek("R8 rising code only", A_EVT, 32'h0, 32'h0000_0001);
        @(negedge clk); pad = 32'h0;
        settle(4);
        peek("R8 falling code added, none code silent", A_EVT, 32'h0000_0007, 32'h0000_0003);

        // R12 edge and clear on the same clock edge
        wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_SA, 32'h0);
        @(negedge clk); pad = 32'h0000_0008;
        @(negedge clk);
        @(negedge clk); addr = A_EVT; we = 1'b1; wdata = 32'h0000_0008;
        @(negedge clk); we = 1'b0;
        peek("R12 edge beats clear", A_EVT, 32'h0000_0008, 32'h0000_0008);

        // R2 register map
        wr(A_OD, 32'h1234_5678);
        peek("R2 open-drain word", A_OD, 32'h1234_5678, 32'h1234_5678);
        wr(A_NONE, 32'hFFFF_FFFF);
        peek("R2 unmapped index reads zero", A_NONE, 32'h0, 32'h0);
        peek("R2 unmapped write leaves enable", A_EN, 32'h0, 32'h0);

        settle(2);
        finish_run();
    end
endmodule